// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the receive byte stream of an Ethernet MAC, starting at the strobe that marks the first byte after the start-of-frame delimiter. It decides whether the frame is kept. The decision uses the six destination bytes, a station address, a 64-entry multicast hash table and three mode bits. The mode bits select promiscuous reception, refusal of frames to the station's own address, and refusal of broadcasts. When a frame is kept, three flags say why: station match, hash-table match or broadcast.

An optional external filter can veto a frame. It does so by pulling an active-low reject line at any point inside a fixed window of received bytes. When that filter is built in, any frame it does not veto is kept. The verdict and its flags are issued with a one-cycle done strobe when the veto window closes, or at end of frame if that comes first. The verdict and flags then hold until the next start strobe.

Top module: `rx_addr_filter`

## Requirements
- R1: Destination byte k (k = 0 first after `sof_i`) is compared with `station_addr_i[8k+7:8k]`. A unicast destination (bit 0 of byte 0 is 0) equal to the station address is accepted with the physical flag set.
- R2: With `drop_ucast_i` = 1, a destination equal to the station address gives no physical match, and the physical flag stays 0.
- R3: A multicast destination (bit 0 of byte 0 is 1, not all ones) is hashed with CRC-32. The CRC is reflected, uses polynomial 0xEDB88320 and starts at all ones. It runs over the six bytes, least significant bit first, with no final inversion. Bits [31:26] of the result select a bit of `lfilter_i`. If that bit is 1 the frame is accepted with the logical flag set. An all-zero table therefore accepts no such frame.
- R4: With `drop_bcast_i` = 0, an all-ones destination is accepted with only the broadcast flag set, even when its hash bit is 1.
- R5: With `drop_bcast_i` = 1, an all-ones destination is accepted only if its hash bit is 1, and then both the logical and broadcast flags are 1.
- R6: With `promisc_i` = 1, every frame with six destination bytes is accepted, whatever the unicast/broadcast drop bits or the external reject. The flags show the non-promiscuous match result, so they are all 0 when promiscuous mode alone admits the frame.
- R7: A refused frame reports all three flags 0. A frame that ends before six destination bytes is refused, even in promiscuous mode.
- R8: With EXT_REJECT = 1, `ext_rej_n_i` low in any cycle after `sof_i` up to and including the cycle carrying byte REJ_WINDOW refuses a non-promiscuous frame. A low level after that cycle has no effect.
- R9: With EXT_REJECT = 1, a frame that is not vetoed is accepted even without an internal match, and then all flags are 0. With EXT_REJECT = 0, `ext_rej_n_i` is ignored and only the address match decides.
- R10: `done_o` pulses for one cycle, exactly once per frame. It comes in the cycle after the one carrying byte REJ_WINDOW, or in the cycle after `eof_i` if `eof_i` comes first.
- R11: After reset, and in the cycle after `sof_i`, `accept_o` and the flags are 0. From `done_o` onward they hold until the next `sof_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-frame strobe, in the cycle before the first destination byte |
| byte_vld_i | input | 1 | A received byte is present on `byte_i` |
| byte_i | input | 8 | Received byte |
| eof_i | input | 1 | End-of-frame strobe, in a cycle after the last byte |
| station_addr_i | input | 8*ADDR_BYTES | Station address, byte k at bits [8k+7:8k] |
| lfilter_i | input | 2**HASH_BITS | Multicast hash table |
| promisc_i | input | 1 | Accept every well-formed frame |
| drop_ucast_i | input | 1 | Refuse frames to the station address |
| drop_bcast_i | input | 1 | Refuse broadcasts without a hash hit |
| ext_rej_n_i | input | 1 | External veto, active low |
| done_o | output | 1 | One-cycle verdict strobe |
| accept_o | output | 1 | Frame accepted |
| phys_hit_o | output | 1 | Accepted on station address |
| lfilt_hit_o | output | 1 | Accepted on hash table |
| bcast_hit_o | output | 1 | Accepted as broadcast |

## Verification
The bench drives the same stimulus into two builds of the block. The first has the defaults: a veto window of 64 bytes with the external veto present. The second has a 16-byte window with no external veto. The first build makes the window edges at bytes 64 and 65 reachable, and it shows that the veto overrides internal matches and lets unmatched frames through. The second build shows the pure address filter and a window that closes before end of frame on short traffic. Hash expectations come from a bitwise CRC written in the bench, and the table is built to hit or miss the computed index.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

   typedef struct packed {
      logic phys;
      logic lfilt;
      logic bcast;
   } match_t;

   // one byte through the reflected CRC-32, least significant bit first
   function automatic logic [31:0] crc_step_byte(input logic [31:0] crc_in,
                                                 input logic [7:0]  data);
      logic [31:0] c;
      c = crc_in ^ {24'd0, data};
      for (int i = 0; i < 8; i++) begin
         c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/rx_crc_hash.sv
module rx_crc_hash #(
   parameter int HASH_BITS = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear_i,
   input  logic                 take_i,
   input  logic [7:0]           data_i,
   output logic [HASH_BITS-1:0] hash_idx_o
);
   import rx_filt_pkg::*;

   logic [31:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc_q <= '1;
      else if (clear_i) crc_q <= '1;
      else if (take_i)  crc_q <= crc_step_byte(crc_q, data_i);
   end

   // table index: top bits of the running register, bit 31 most significant
   assign hash_idx_o = crc_q[31 -: HASH_BITS];

endmodule

// File: rtl/rx_rej_window.sv
module rx_rej_window #(
   parameter int REJ_WINDOW = 64,
   parameter int CNT_W      = $clog2(REJ_WINDOW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof_i,
   input  logic             byte_vld_i,
   input  logic             eof_i,
   input  logic             ext_rej_n_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             take_o,
   output logic             close_o,
   output logic             rej_seen_o
);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(REJ_WINDOW - 1);

   logic active_q;
   logic rej_q;
   logic [CNT_W-1:0] cnt_q;

   assign take_o     = active_q && !sof_i && byte_vld_i && !eof_i;
   assign close_o    = active_q && !sof_i && (eof_i || (take_o && cnt_q == LAST_CNT));
   assign rej_seen_o = rej_q || (active_q && !sof_i && !ext_rej_n_i);
   assign cnt_o      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rej_q    <= 1'b0;
         cnt_q    <= '0;
      end else if (sof_i) begin
         active_q <= 1'b1;
         rej_q    <= 1'b0;
         cnt_q    <= '0;
      end else if (active_q) begin
         if (take_o)       cnt_q    <= cnt_q + 1'b1;
         if (!ext_rej_n_i) rej_q    <= 1'b1;
         if (close_o)      active_q <= 1'b0;
      end
   end

endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS  = 6,
   parameter int AW         = 8 * ADDR_BYTES
) (
   input  logic [AW-1:0]           dest_i,
   input  logic [AW-1:0]           station_i,
   input  logic [2**HASH_BITS-1:0] lfilter_i,
   input  logic [HASH_BITS-1:0]    hash_idx_i,
   input  logic                    drop_ucast_i,
   input  logic                    drop_bcast_i,
   output rx_filt_pkg::match_t     match_o
);
   logic is_mcast, is_bcast, own_addr, hash_hit;

   assign is_mcast = dest_i[0];
   assign is_bcast = &dest_i;
   assign own_addr = (dest_i == station_i);
   assign hash_hit = lfilter_i[hash_idx_i];

   always_comb begin
      match_o.phys  = !is_mcast && own_addr && !drop_ucast_i;
      // a broadcast reaches the hash path only when broadcasts are dropped
      match_o.lfilt = is_mcast && hash_hit && (!is_bcast || drop_bcast_i);
      match_o.bcast = is_bcast && (!drop_bcast_i || hash_hit);
   end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS  = 6,
   parameter int REJ_WINDOW = 64,
   parameter bit EXT_REJECT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sof_i,
   input  logic                      byte_vld_i,
   input  logic [7:0]                byte_i,
   input  logic                      eof_i,
   input  logic [8*ADDR_BYTES-1:0]   station_addr_i,
   input  logic [2**HASH_BITS-1:0]   lfilter_i,
   input  logic                      promisc_i,
   input  logic                      drop_ucast_i,
   input  logic                      drop_bcast_i,
   input  logic                      ext_rej_n_i,
   output logic                      done_o,
   output logic                      accept_o,
   output logic                      phys_hit_o,
   output logic                      lfilt_hit_o,
   output logic                      bcast_hit_o
);
   import rx_filt_pkg::*;

   localparam int AW    = 8 * ADDR_BYTES;
   localparam int CNT_W = $clog2(REJ_WINDOW + 1);
   localparam logic [CNT_W-1:0] ADDR_CNT = CNT_W'(ADDR_BYTES);

   initial begin
      if (ADDR_BYTES < 1 || REJ_WINDOW <= ADDR_BYTES)
         $fatal(1, "rx_addr_filter: REJ_WINDOW must exceed ADDR_BYTES");
      if (HASH_BITS < 1 || HASH_BITS > 12)
         $fatal(1, "rx_addr_filter: HASH_BITS out of range");
   end

   logic [CNT_W-1:0]     cnt;
   logic                 take, close, rej_seen;
   logic [HASH_BITS-1:0] hash_idx;
   logic [AW-1:0]        dest_q;
   logic                 addr_full, in_addr;
   match_t               match;
   logic                 base_acc, acc_next;
   match_t               flags_next, flags_q;
   logic                 done_q, acc_q;

   rx_rej_window #(.REJ_WINDOW(REJ_WINDOW), .CNT_W(CNT_W)) u_win (
      .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .byte_vld_i(byte_vld_i),
      .eof_i(eof_i), .ext_rej_n_i(ext_rej_n_i), .cnt_o(cnt), .take_o(take),
      .close_o(close), .rej_seen_o(rej_seen)
   );

   assign in_addr   = take && (cnt < ADDR_CNT);
   assign addr_full = (cnt >= ADDR_CNT);

   rx_crc_hash #(.HASH_BITS(HASH_BITS)) u_hash (
      .clk(clk), .rst_n(rst_n), .clear_i(sof_i), .take_i(in_addr),
      .data_i(byte_i), .hash_idx_o(hash_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dest_q <= '0;
      else if (sof_i)   dest_q <= '0;
      else if (in_addr) dest_q[8*int'(cnt) +: 8] <= byte_i;
   end

   rx_addr_match #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS), .AW(AW)) u_match (
      .dest_i(dest_q), .station_i(station_addr_i), .lfilter_i(lfilter_i),
      .hash_idx_i(hash_idx), .drop_ucast_i(drop_ucast_i),
      .drop_bcast_i(drop_bcast_i), .match_o(match)
   );

   generate
      if (EXT_REJECT) begin : g_ext
         assign base_acc = !rej_seen;
      end else begin : g_int
         assign base_acc = match.phys || match.lfilt || match.bcast;
      end
   endgenerate

   assign acc_next   = addr_full && (promisc_i || base_acc);
   assign flags_next = acc_next ? match : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         acc_q   <= 1'b0;
         flags_q <= '0;
      end else if (sof_i) begin
         done_q  <= 1'b0;
         acc_q   <= 1'b0;
         flags_q <= '0;
      end else begin
         done_q <= close;
         if (close) begin
            acc_q   <= acc_next;
            flags_q <= flags_next;
         end
      end
   end

   assign done_o      = done_q;
   assign accept_o    = acc_q;
   assign phys_hit_o  = flags_q.phys;
   assign lfilt_hit_o = flags_q.lfilt;
   assign bcast_hit_o = flags_q.bcast;

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
   input logic clk,
   input logic rst_n,
   input logic sof_i,
   input logic done_o,
   input logic accept_o,
   input logic phys_hit_o,
   input logic lfilt_hit_o,
   input logic bcast_hit_o
);
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_flags_need_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (phys_hit_o || lfilt_hit_o || bcast_hit_o) |-> accept_o);

   assert_sof_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sof_i |=> (!accept_o && !done_o && !phys_hit_o && !lfilt_hit_o && !bcast_hit_o));

   assert_verdict_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(accept_o) |-> (done_o || $past(sof_i)));

   assert_phys_not_bcast_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(phys_hit_o && bcast_hit_o));

endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .done_o(done_o),
   .accept_o(accept_o), .phys_hit_o(phys_hit_o), .lfilt_hit_o(lfilt_hit_o),
   .bcast_hit_o(bcast_hit_o)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
   localparam int WIN_A = 64;
   localparam int WIN_B = 16;
   localparam logic [47:0] SA  = 48'h103254769802;
   localparam logic [47:0] SAR = 48'h029876543210;
   localparam logic [47:0] MC  = 48'h78565E000001;
   localparam logic [47:0] BC  = 48'hFFFFFFFFFFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sof = 0, bvld = 0, eof = 0, rej_n = 1;
   logic [7:0] bdat = 0;
   logic [47:0] sa = SA;
   logic [63:0] filt = '0;
   logic prom = 0, du = 0, db = 0;
   logic done_a, acc_a, ph_a, lf_a, bc_a;
   logic done_b, acc_b, ph_b, lf_b, bc_b;
   int n_checks = 0, n_errs = 0;

   always #2.5 clk = ~clk;

   rx_addr_filter #(.REJ_WINDOW(WIN_A), .EXT_REJECT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .sof_i(sof), .byte_vld_i(bvld), .byte_i(bdat),
      .eof_i(eof), .station_addr_i(sa), .lfilter_i(filt), .promisc_i(prom),
      .drop_ucast_i(du), .drop_bcast_i(db), .ext_rej_n_i(rej_n),
      .done_o(done_a), .accept_o(acc_a), .phys_hit_o(ph_a),
      .lfilt_hit_o(lf_a), .bcast_hit_o(bc_a));

   rx_addr_filter #(.REJ_WINDOW(WIN_B), .EXT_REJECT(1'b0)) dut_nx (
      .clk(clk), .rst_n(rst_n), .sof_i(sof), .byte_vld_i(bvld), .byte_i(bdat),
      .eof_i(eof), .station_addr_i(sa), .lfilter_i(filt), .promisc_i(prom),
      .drop_ucast_i(du), .drop_bcast_i(db), .ext_rej_n_i(rej_n),
      .done_o(done_b), .accept_o(acc_b), .phys_hit_o(ph_b),
      .lfilt_hit_o(lf_b), .bcast_hit_o(bc_b));

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int hash_of(input logic [47:0] d);
      logic [31:0] r;
      logic fb;
      r = '1;
      for (int i = 0; i < 48; i++) begin
         fb = r[0] ^ d[i];
         r  = {1'b0, r[31:1]};
         if (fb) r = r ^ 32'hEDB88320;
      end
      return int'(r[31:26]);
   endfunction

   // expected {accept, phys, lfilt, bcast}
   function automatic logic [3:0] model(input logic [47:0] d, input int n,
                                        input bit ext, input bit vetoed);
      logic mc, bcst, hh, p, l, b, acc;
      mc   = d[0];
      bcst = &d;
      hh   = filt[hash_of(d)];
      p    = !mc && (d == sa) && !du;
      l    = mc && hh && (!bcst || db);
      b    = bcst && (!db || hh);
      acc  = (n >= 6) && (prom || (ext ? !vetoed : (p || l || b)));
      return acc ? {1'b1, p, l, b} : 4'b0;
   endfunction

   function automatic int close_at(input int w, input int n, input bit with_eof);
      if (n >= w) return w;
      return with_eof ? n + 1 : -1;
   endfunction

   task automatic run_frame(input logic [47:0] d, input int n, input bit with_eof,
                            input int rej, input string req);
      int t_end, cl_a, cl_b, seen_a, seen_b, at_a, at_b;
      logic [3:0] ex_a, ex_b, cap_a, cap_b;
      t_end = 1 + n + (with_eof ? 1 : 0) + 3;
      cl_a  = close_at(WIN_A, n, with_eof);
      cl_b  = close_at(WIN_B, n, with_eof);
      ex_a  = model(d, n, 1'b1, (rej >= 0) && (rej < n) && (rej < WIN_A));
      ex_b  = model(d, n, 1'b0, 1'b0);
      seen_a = 0; seen_b = 0; at_a = -1; at_b = -1; cap_a = '0; cap_b = '0;
      for (int c = 0; c <= t_end; c++) begin
         @(negedge clk);
         if (c > 0) begin
            if (done_a) begin seen_a++; at_a = c - 1; cap_a = {acc_a, ph_a, lf_a, bc_a}; end
            if (done_b) begin seen_b++; at_b = c - 1; cap_b = {acc_b, ph_b, lf_b, bc_b}; end
         end
         sof   = (c == 0);
         bvld  = (c >= 1) && (c <= n);
         bdat  = (c >= 1 && c <= 6) ? d[(c-1)*8 +: 8] : 8'((c * 37) & 255);
         eof   = with_eof && (c == n + 1);
         rej_n = !((rej >= 0) && (c == rej + 1));
         if (c >= t_end) begin sof = 0; bvld = 0; eof = 0; rej_n = 1; end
      end
      check(seen_a == 1, "R10", {req, " done count win64"}, seen_a, 1);
      check(at_a == cl_a, "R10", {req, " done cycle win64"}, at_a, cl_a);
      check(cap_a == ex_a, req, "verdict win64/ext", {28'd0, cap_a}, {28'd0, ex_a});
      check({acc_a, ph_a, lf_a, bc_a} == ex_a, "R11", {req, " hold win64"},
            {28'd0, acc_a, ph_a, lf_a, bc_a}, {28'd0, ex_a});
      check(seen_b == 1, "R10", {req, " done count win16"}, seen_b, 1);
      check(at_b == cl_b, "R10", {req, " done cycle win16"}, at_b, cl_b);
      check(cap_b == ex_b, req, "verdict win16/noext", {28'd0, cap_b}, {28'd0, ex_b});
   endtask

   task automatic set_mode(input bit p, input bit u, input bit b, input logic [63:0] f);
      prom = p; du = u; db = b; filt = f;
   endtask

   task automatic t_reset;
      check({done_a, acc_a, ph_a, lf_a, bc_a} == 5'b0, "R11", "reset outputs win64",
            {27'd0, done_a, acc_a, ph_a, lf_a, bc_a}, 0);
      check({done_b, acc_b, ph_b, lf_b, bc_b} == 5'b0, "R11", "reset outputs win16",
            {27'd0, done_b, acc_b, ph_b, lf_b, bc_b}, 0);
   endtask

   task automatic t_unicast;   // R1, R9
      set_mode(0, 0, 0, '0);
      run_frame(SA, 20, 1, -1, "R1");
      run_frame(SAR, 20, 1, -1, "R9");
   endtask

   task automatic t_drop_ucast;   // R2
      set_mode(0, 1, 0, '0);
      run_frame(SA, 20, 1, -1, "R2");
   endtask

   task automatic t_multicast;   // R3
      set_mode(0, 0, 0, 64'd1 << hash_of(MC));
      run_frame(MC, 20, 1, -1, "R3");
      set_mode(0, 0, 0, ~(64'd1 << hash_of(MC)));
      run_frame(MC, 20, 1, -1, "R3");
      set_mode(0, 0, 0, '0);
      run_frame(MC, 20, 1, -1, "R3");
   endtask

   task automatic t_broadcast;   // R4, R5
      set_mode(0, 0, 0, '1);
      run_frame(BC, 20, 1, -1, "R4");
      set_mode(0, 0, 1, '0);
      run_frame(BC, 20, 1, -1, "R5");
      set_mode(0, 0, 1, 64'd1 << hash_of(BC));
      run_frame(BC, 20, 1, -1, "R5");
   endtask

   task automatic t_promisc;   // R6
      set_mode(1, 1, 1, '0);
      run_frame(SAR, 20, 1, -1, "R6");
      run_frame(SA, 20, 1, -1, "R6");
      run_frame(BC, 20, 1, -1, "R6");
      set_mode(1, 0, 0, '0);
      run_frame(SA, 70, 1, 3, "R6");
   endtask

   task automatic t_ext_reject;   // R8
      set_mode(0, 0, 0, '0);
      run_frame(SA, 70, 1, 10, "R8");
      run_frame(SA, 70, 1, 63, "R8");
      run_frame(SA, 70, 1, 64, "R8");
      run_frame(SA, 70, 1, 0, "R8");
   endtask

   task automatic t_short;   // R7
      set_mode(1, 0, 0, '1);
      run_frame(SA, 3, 1, -1, "R7");
      set_mode(0, 0, 0, '0);
      run_frame(MC, 20, 1, 2, "R7");
   endtask

   task automatic t_timing;   // R10
      set_mode(0, 0, 0, '0);
      run_frame(SA, 8, 1, -1, "R10");
      run_frame(SA, 40, 1, -1, "R10");
   endtask

   initial begin
      #(200000 * 5);
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      t_unicast;
      t_drop_ucast;
      t_multicast;
      t_broadcast;
      t_promisc;
      t_ext_reject;
      t_short;
      t_timing;
      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
   end

endmodule